// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block raises the interrupt line of a 16-bit general-purpose I/O expander. The expander is organised as two independent 8-bit ports. Each port keeps a snapshot of its pin levels, and that snapshot is refreshed on the clock edge where the port's input-value read strobe is high. The block compares the synchronized live pin levels with the snapshot, bit by bit. Only bits whose direction is input take part in the compare. When any input bit differs from its snapshot, the block pulls the active-low open-drain interrupt line low.

The interrupt is level-based and needs no acknowledge. It goes away by itself when every changed pin returns to its snapshot level. A read of one port loads that port's snapshot with the current levels, which clears that port's share of the interrupt and leaves the other port's share alone. A pin that is switched from output to input while its level differs from its snapshot raises an interrupt. This spurious interrupt is reproduced on purpose.

A controller with three states drives the output. `ST_PRIME` is entered at reset. The snapshots follow the synchronized pins for `SYNC_STAGES+1` cycles and the output stays released, then the transition *prime_done* moves the controller to `ST_QUIET`. From `ST_QUIET`, the transition *change_seen* (any port mismatch) moves to `ST_ALERT`. From `ST_ALERT`, the transition *all_settled* (no mismatch) moves back to `ST_QUIET`. The output is decoded from the state register alone, so the line is glitch-free and lags the compare by one cycle.

Top module: `pcig_top`

## Requirements
- R1: With direction bit = 1 (input), a pin level that differs from its snapshot drives `int_oe_o` to 1. The line is low for the first two rising edges after the pin change and high after the third rising edge (two synchronizer stages plus one state register).
- R2: When every differing input pin returns to its snapshot level, with no read, `int_oe_o` returns to 0 after the third rising edge following the return.
- R3: On a rising edge with `rd_i[k]` = 1, port k's snapshot loads the synchronized pin levels of that port's byte (bits `8k+7..8k`). `rd_data_o` for that byte shows the loaded value after that edge. The port's contribution is cleared, so `int_oe_o` falls after the following edge if no other cause remains.
- R4: Pins with direction bit = 0 (output) never affect `int_oe_o`, whatever their level.
- R5: A read of port 0 does not clear a pending change on port 1, and a read of port 1 does not clear a pending change on port 0.
- R6: If a direction bit changes from 0 to 1 while the pin level differs from its snapshot, `int_oe_o` rises after the next rising edge.
- R7: `int_n_o` is always the inverse of `int_oe_o`. `int_oe_o` = 1 means the line is driven low.
- R8: After reset is released, the output stays at 0 for the first `SYNC_STAGES+1` rising edges while the snapshots follow the pins. If the pins were steady, no interrupt is present afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 16 | Raw pin levels; byte k belongs to port k |
| dir_i | input | 16 | Direction per pin, 1 = input, 0 = output |
| rd_i | input | 2 | Per-port read strobe; loads the snapshot |
| rd_data_o | output | 16 | Snapshot contents (read data) per port byte |
| int_oe_o | output | 1 | 1 = drive the interrupt line low |
| int_n_o | output | 1 | Interrupt line level as seen on the wire |

## Verification
The bench walks a single toggled bit across all sixteen pins, once as an input and once as an output. This separates which pins may raise the line, and each walk also checks the exact cycle of assertion and release. A pair of changes on both ports, cleared one read at a time, shows that each port's share of the interrupt is separate. A pin toggled while it is an output and then turned into an input shows the spurious interrupt. A long pseudo-random sweep over pins, directions and read strobes is checked against a snapshot model kept in the bench. This catches mixed patterns that the directed walks miss.

// File: rtl/pcig_pkg.sv
package pcig_pkg;
    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_QUIET = 2'd1,
        ST_ALERT = 2'd2
    } irq_state_t;
endpackage

// File: rtl/pcig_sync.sv
module pcig_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pcig_port.sv
module pcig_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] dir_i,
    input  logic         load_i,
    output logic [W-1:0] snap_o,
    output logic         mismatch_o
);
    logic [W-1:0] snap_q;
    logic [W-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      snap_q <= '0;
        else if (load_i) snap_q <= sync_i;
    end

    // only input-direction bits may report a difference
    assign diff       = (sync_i ^ snap_q) & dir_i;
    assign mismatch_o = |diff;
    assign snap_o     = snap_q;

    // R3: a load captures the synchronized levels of that edge
    assert_snap_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (snap_q == $past(sync_i)));

    // R3: right after a load, the port reports nothing unless the pins moved
    assert_load_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ($stable(sync_i) -> !mismatch_o));
endmodule

// File: rtl/pcig_top.sv
module pcig_top #(
    parameter int PORT_W      = 8,
    parameter int NUM_PORTS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS*PORT_W-1:0]   pins_i,
    input  logic [NUM_PORTS*PORT_W-1:0]   dir_i,
    input  logic [NUM_PORTS-1:0]          rd_i,
    output logic [NUM_PORTS*PORT_W-1:0]   rd_data_o,
    output logic                          int_oe_o,
    output logic                          int_n_o
);
    import pcig_pkg::*;

    localparam int TOTAL_W   = NUM_PORTS * PORT_W;
    localparam int PRIME_CYC = SYNC_STAGES + 1;
    localparam int CNT_W     = $clog2(PRIME_CYC + 1);

    irq_state_t          state_q, state_d;
    logic [CNT_W-1:0]    prime_cnt_q;
    logic [TOTAL_W-1:0]  sync_pins;
    logic [NUM_PORTS-1:0] port_mis;
    logic                any_change;
    logic                priming;
    logic                prime_done;

    pcig_sync #(.W(TOTAL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_i),
        .q_o   (sync_pins)
    );

    assign priming = (state_q == ST_PRIME);

    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
        pcig_port #(.W(PORT_W)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .sync_i     (sync_pins[k*PORT_W +: PORT_W]),
            .dir_i      (dir_i[k*PORT_W +: PORT_W]),
            .load_i     (priming | rd_i[k]),
            .snap_o     (rd_data_o[k*PORT_W +: PORT_W]),
            .mismatch_o (port_mis[k])
        );
    end

    assign any_change = |port_mis;
    assign prime_done = (prime_cnt_q == CNT_W'(PRIME_CYC - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_PRIME;
            prime_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (priming) prime_cnt_q <= prime_cnt_q + 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: if (prime_done)  state_d = ST_QUIET;
            ST_QUIET: if (any_change)  state_d = ST_ALERT;
            ST_ALERT: if (!any_change) state_d = ST_QUIET;
            default:                   state_d = ST_PRIME;
        endcase
    end

    // outputs decoded from the state register only
    always_comb begin
        int_oe_o = 1'b0;
        unique case (state_q)
            ST_ALERT: int_oe_o = 1'b1;
            default:  int_oe_o = 1'b0;
        endcase
        int_n_o = ~int_oe_o;
    end

    assert_change_raises_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!priming && any_change) |=> int_oe_o);

    assert_settle_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!priming && !any_change) |=> !int_oe_o);

    assert_prime_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        priming |-> !int_oe_o);

    assert_rise_has_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_oe_o) |-> $past(any_change));
endmodule

// File: tb/test_pcig_top.sv
`timescale 1ns/100ps
module test_pcig_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pins = '0;
    logic [W-1:0] dir = '1;
    logic [1:0]   rd = '0;
    logic [W-1:0] rd_data;
    logic         int_oe;
    logic         int_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [W-1:0] snap_m;   // bench model of the snapshots
    logic [31:0]  seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    pcig_top i_pcig_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_i    (pins),
        .dir_i     (dir),
        .rd_i      (rd),
        .rd_data_o (rd_data),
        .int_oe_o  (int_oe),
        .int_n_o   (int_n)
    );

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_int(input string req, input logic exp);
        n_checks++;
        if (int_oe !== exp || int_n !== ~exp) begin
            n_fail++;
            $display("FAIL %s int_oe=%b int_n=%b expected int_oe=%b", req, int_oe, int_n, exp);
        end
    endtask

    task automatic chk_data(input string req, input logic [W-1:0] exp);
        n_checks++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s rd_data=%h expected %h", req, rd_data, exp);
        end
    endtask

    // read strobe for one edge; model loads the byte(s)
    task automatic do_read(input logic [1:0] which);
        rd = which;
        @(posedge clk);
        if (which[0]) snap_m[7:0]  = pins[7:0];
        if (which[1]) snap_m[15:8] = pins[15:8];
        @(negedge clk);
        rd = '0;
    endtask

    function automatic logic exp_int();
        return |((pins ^ snap_m) & dir);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        pins = 16'hA5C3;
        dir  = '1;
        repeat (3) @(negedge clk);
        // R8: output released during reset and priming
        chk_int("R8 in reset", 1'b0);
        rst_n = 1'b1;
        edges(1); chk_int("R8 priming", 1'b0);
        edges(4); chk_int("R8 quiet after prime", 1'b0);
        snap_m = pins;
        chk_data("R8 snapshot tracks pins", pins);

        // R1/R2/R7: walk one toggled input bit over all pins
        for (int b = 0; b < W; b++) begin
            pins[b] = ~pins[b];
            edges(2); chk_int($sformatf("R1 bit%0d not yet", b), 1'b0);
            edges(1); chk_int($sformatf("R1 bit%0d raised", b), 1'b1);
            pins[b] = ~pins[b];
            edges(2); chk_int($sformatf("R2 bit%0d still held", b), 1'b1);
            edges(1); chk_int($sformatf("R2 bit%0d self clear", b), 1'b0);
        end

        // R4: output-direction pins are ignored
        for (int b = 0; b < W; b++) begin
            dir = '1; dir[b] = 1'b0;
            pins[b] = ~pins[b];
            edges(4); chk_int($sformatf("R4 output bit%0d ignored", b), 1'b0);
            // R6 on the same bit: switching to input raises the spurious interrupt
            dir[b] = 1'b1;
            edges(1); chk_int($sformatf("R6 bit%0d spurious", b), 1'b1);
            do_read(b < 8 ? 2'b01 : 2'b10);
            chk_data($sformatf("R3 bit%0d read data", b), snap_m);
            edges(1); chk_int($sformatf("R3 bit%0d read clears", b), 1'b0);
        end

        // R5: independent ports
        dir = '1;
        pins[3]  = ~pins[3];
        pins[12] = ~pins[12];
        edges(4); chk_int("R5 both pending", 1'b1);
        do_read(2'b01);
        edges(2); chk_int("R5 port1 still pending after port0 read", 1'b1);
        chk_data("R5 port0 read data", snap_m);
        do_read(2'b10);
        edges(1); chk_int("R5 cleared after port1 read", 1'b0);
        pins[1]  = ~pins[1];
        pins[9]  = ~pins[9];
        edges(4);
        do_read(2'b10);
        edges(2); chk_int("R5 port0 still pending after port1 read", 1'b1);
        do_read(2'b01);
        edges(1); chk_int("R5 cleared after port0 read", 1'b0);

        // sweep: pseudo-random pins, directions and reads vs. model
        for (int i = 0; i < 400; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            pins = seed[31:16];
            seed = seed * 32'd1103515245 + 32'd12345;
            dir  = seed[31:16] | seed[15:0];
            edges(4);
            chk_int($sformatf("R1/R4 sweep %0d", i), exp_int());
            if (seed[3:2] != 2'b00) begin
                do_read(seed[3:2]);
                chk_data($sformatf("R3 sweep %0d data", i), snap_m);
                edges(1);
                chk_int($sformatf("R5 sweep %0d after read", i), exp_int());
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule